// File: doc/BRIEF.md
# Line-Sequential Colour Channel Selector

Some linear image sensors deliver a whole line of red pixels, then a whole line of green, then a whole line of blue. This block decides which colour an analogue front end is processing at any moment. It produces three 2-bit selects: one for the input multiplexer, one for the offset-register bank and one for the gain-register bank. It also produces the power-down and mono controls that switch the front end to a single processing path.

Each select takes its colour from one of two sources. The first is a static configuration field. The second is a rotation state that steps red, green, blue, red on each rising edge of an external asynchronous step pin. A force bit separates the input multiplexer from the offset/gain selection, so the input can be fixed while the register banks still rotate. A one-cycle clear strobe, issued by software, returns the rotation to red.

Top module: `line_colour_select`

## Requirements
- R1: When `lbl_en` is 1, `pd_green`, `pd_blue` and `mono_force` are all 1. When `lbl_en` is 0, all three are 0.
- R2: With `acyc_en`=0 and `force_en`=0, `in_sel`, `ofs_sel` and `gain_sel` all equal the decoded `intm` field. The colour code is 00 red, 01 green, 10 blue.
- R3: With `acyc_en`=1 and `force_en`=0, `in_sel`, `ofs_sel` and `gain_sel` all equal the rotation state.
- R4: With `force_en`=1 and `acyc_en`=0, `in_sel` equals the decoded `fm` field, and `ofs_sel` and `gain_sel` equal the decoded `intm` field.
- R5: With `force_en`=1 and `acyc_en`=1, `in_sel` equals the decoded `fm` field, and `ofs_sel` and `gain_sel` equal the rotation state.
- R6: Each low-to-high transition of `acyc_pin` advances the rotation exactly one step, 00→01→10→00, however many cycles the pin stays high.
- R7: A rise of `acyc_pin` first sampled at clock edge E changes the selects just after edge E+2. The selects are unchanged after E and E+1.
- R8: A `acyc_clr` pulse sampled at an edge sets the rotation to red (00) at that edge. The clear takes priority over a step that falls in the same cycle.
- R9: After the asynchronous active-low reset, the rotation is red. With `acyc_en`=1, all rotating selects read 00.
- R10: The code 11 in `intm` or `fm` selects red (00).
- R11: The select mode table applies whether `lbl_en` is 0 or 1.
- R12: Pin transitions that complete while `acyc_en`=0 leave the rotation unchanged, as seen once `acyc_en` is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acyc_pin | input | 1 | Asynchronous rotation step pin |
| acyc_clr | input | 1 | One-cycle strobe that returns the rotation to red |
| lbl_en | input | 1 | Line-sequential mode enable |
| acyc_en | input | 1 | Pin-driven rotation enable |
| force_en | input | 1 | Input multiplexer taken from `fm` |
| intm | input | 2 | Static colour field for the selects |
| fm | input | 2 | Static colour field for the input multiplexer when forced |
| in_sel | output | 2 | Input multiplexer select |
| ofs_sel | output | 2 | Offset register bank select |
| gain_sel | output | 2 | Gain register bank select |
| mono_force | output | 1 | Forces single-path mono operation |
| pd_green | output | 1 | Power-down for the green path |
| pd_blue | output | 1 | Power-down for the blue path |

## Verification
The step and gating assertions assume that `acyc_en` holds steady while a synchronized pin edge is in flight. They also assume that `acyc_clr` is a single-cycle strobe. The stimulus changes the configuration only at falling edges, and only after the pin has been low long enough for the synchronizer to settle. It never changes `acyc_en` during a pulse. Random pulses keep the pin low for at least four cycles between rises, so every rise is seen as a separate edge. One directed case places a clear exactly on the step cycle, to exercise the priority rule.

// File: rtl/colsel_pkg.sv
package colsel_pkg;

    localparam int COL_W = 2;

    typedef enum logic [COL_W-1:0] {
        COL_RED   = 2'b00,
        COL_GREEN = 2'b01,
        COL_BLUE  = 2'b10
    } colour_e;

    // Register field to colour; the unused code falls back to red.
    function automatic colour_e field_to_colour(input logic [COL_W-1:0] f);
        colour_e c;
        case (f)
            2'b01:   c = COL_GREEN;
            2'b10:   c = COL_BLUE;
            default: c = COL_RED;
        endcase
        return c;
    endfunction

    // Rotation order red -> green -> blue -> red.
    function automatic colour_e rotate_colour(input colour_e c);
        colour_e n;
        case (c)
            COL_RED:   n = COL_GREEN;
            COL_GREEN: n = COL_BLUE;
            default:   n = COL_RED;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/colsel_pulse_sync.sv
module colsel_pulse_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic rise_o
);
    localparam int TOP = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[TOP-1:0], pin_async};
        st_d.last  = st_q.chain[TOP];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.chain[TOP] & ~st_q.last;

    // R6
    single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/colsel_rotor.sv
module colsel_rotor
    import colsel_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    advance,
    input  logic    clear,
    output colour_e rot_o
);
    typedef struct packed {
        colour_e rot;
    } rotor_state_t;

    rotor_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear)        st_d.rot = COL_RED;
        else if (advance) st_d.rot = rotate_colour(st_q.rot);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{rot: COL_RED};
        else        st_q <= st_d;
    end

    assign rot_o = st_q.rot;

    // R6
    legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rot_o != 2'b11);

    // R8
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> rot_o == COL_RED);

    // R6
    step_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !clear && rot_o == COL_BLUE) |=> rot_o == COL_RED);

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !clear) |=> $stable(rot_o));

endmodule

// File: rtl/colsel_route.sv
module colsel_route
    import colsel_pkg::*;
(
    input  logic             acyc_en,
    input  logic             force_en,
    input  logic [COL_W-1:0] intm,
    input  logic [COL_W-1:0] fm,
    input  colour_e          rot,
    output logic [COL_W-1:0] in_sel,
    output logic [COL_W-1:0] ofs_sel,
    output logic [COL_W-1:0] gain_sel
);
    colour_e bank_c, input_c;

    always_comb begin
        bank_c  = acyc_en ? rot : field_to_colour(intm);
        input_c = force_en ? field_to_colour(fm) : bank_c;
    end

    assign in_sel   = input_c;
    assign ofs_sel  = bank_c;
    assign gain_sel = bank_c;

endmodule

// File: rtl/line_colour_select.sv
module line_colour_select
    import colsel_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acyc_pin,
    input  logic       acyc_clr,
    input  logic       lbl_en,
    input  logic       acyc_en,
    input  logic       force_en,
    input  logic [1:0] intm,
    input  logic [1:0] fm,
    output logic [1:0] in_sel,
    output logic [1:0] ofs_sel,
    output logic [1:0] gain_sel,
    output logic       mono_force,
    output logic       pd_green,
    output logic       pd_blue
);
    logic    pin_rise;
    logic    step;
    colour_e rot_w;

    colsel_pulse_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (acyc_pin),
        .rise_o    (pin_rise)
    );

    assign step = pin_rise & acyc_en;

    colsel_rotor i_rotor (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (step),
        .clear   (acyc_clr),
        .rot_o   (rot_w)
    );

    colsel_route i_route (
        .acyc_en  (acyc_en),
        .force_en (force_en),
        .intm     (intm),
        .fm       (fm),
        .rot      (rot_w),
        .in_sel   (in_sel),
        .ofs_sel  (ofs_sel),
        .gain_sel (gain_sel)
    );

    assign mono_force = lbl_en;
    assign pd_green   = lbl_en;
    assign pd_blue    = lbl_en;

    // R1
    path_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_green == pd_blue) && (pd_blue == mono_force));

    // R3
    lockstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acyc_en && !force_en) |-> (in_sel == ofs_sel && ofs_sel == gain_sel));

    // R5
    bank_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ofs_sel == gain_sel);

    // R12
    gated_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!acyc_en && !acyc_clr) |=> $stable(rot_w));

endmodule

// File: tb/test_line_colour_select.sv
module test_line_colour_select;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acyc_pin = 1'b0;
    logic       acyc_clr = 1'b0;
    logic       lbl_en = 1'b0;
    logic       acyc_en = 1'b0;
    logic       force_en = 1'b0;
    logic [1:0] intm = 2'b00;
    logic [1:0] fm = 2'b00;
    logic [1:0] in_sel, ofs_sel, gain_sel;
    logic       mono_force, pd_green, pd_blue;

    int checks = 0;
    int failures = 0;
    logic [1:0] rot_m = 2'b00;
    bit done = 1'b0;

    always #2 clk = ~clk;

    line_colour_select i_line_colour_select (
        .clk(clk), .rst_n(rst_n), .acyc_pin(acyc_pin), .acyc_clr(acyc_clr),
        .lbl_en(lbl_en), .acyc_en(acyc_en), .force_en(force_en),
        .intm(intm), .fm(fm), .in_sel(in_sel), .ofs_sel(ofs_sel),
        .gain_sel(gain_sel), .mono_force(mono_force), .pd_green(pd_green),
        .pd_blue(pd_blue)
    );

    function automatic logic [1:0] dec(input logic [1:0] f);
        return (f == 2'b11) ? 2'b00 : f;
    endfunction

    function automatic logic [1:0] nxt(input logic [1:0] c);
        return (c == 2'b10) ? 2'b00 : c + 2'b01;
    endfunction

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        logic [1:0] bank_e, in_e;
        bank_e = acyc_en ? rot_m : dec(intm);
        in_e   = force_en ? dec(fm) : bank_e;
        chk({tag, " R1 pd_green"}, {1'b0, pd_green}, {1'b0, lbl_en});
        chk({tag, " R1 pd_blue"}, {1'b0, pd_blue}, {1'b0, lbl_en});
        chk({tag, " R1 mono"}, {1'b0, mono_force}, {1'b0, lbl_en});
        chk({tag, " R2-R5 in_sel"}, in_sel, in_e);
        chk({tag, " R3 ofs_sel"}, ofs_sel, bank_e);
        chk({tag, " R5 gain_sel"}, gain_sel, bank_e);
    endtask

    task automatic pulse(input int hold);
        @(negedge clk); acyc_pin = 1'b1;
        repeat (hold) @(negedge clk);
        acyc_pin = 1'b0;
        repeat (4) @(negedge clk);
        if (acyc_en) rot_m = nxt(rot_m);
    endtask

    task automatic clear_strobe();
        @(negedge clk); acyc_clr = 1'b1;
        @(negedge clk); acyc_clr = 1'b0;
        rot_m = 2'b00;
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            report();
        end
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        repeat (3) @(negedge clk);
        // R9 reset state
        acyc_en = 1'b1;
        #1 chk("R9 reset in_sel", in_sel, 2'b00);
        chk("R9 reset ofs_sel", ofs_sel, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R9");

        // R7 latency: rise sampled at E1, change after E3
        force_en = 1'b0;
        acyc_pin = 1'b1;
        @(negedge clk); chk("R7 after E", in_sel, 2'b00);
        @(negedge clk); chk("R7 after E+1", in_sel, 2'b00);
        @(negedge clk); chk("R7 after E+2", in_sel, 2'b01);
        rot_m = 2'b01;
        // R6 long pulse gives only one step
        repeat (20) @(negedge clk);
        chk("R6 long high", in_sel, 2'b01);
        acyc_pin = 1'b0;
        repeat (4) @(negedge clk);
        chk("R6 after release", in_sel, 2'b01);
        pulse(1); pulse(1);
        chk("R6 wrap to red", ofs_sel, 2'b00);
        pulse(2);
        chk("R6 green", gain_sel, 2'b01);

        // R8 clear collides with step
        clear_strobe();
        check_all("R8 plain");
        acyc_pin = 1'b1;
        @(negedge clk); @(negedge clk);
        acyc_clr = 1'b1;
        @(negedge clk); acyc_clr = 1'b0;
        chk("R8 collision", in_sel, 2'b00);
        repeat (3) @(negedge clk);
        chk("R8 no late step", in_sel, 2'b00);
        acyc_pin = 1'b0;
        repeat (4) @(negedge clk);

        // R12 pulses ignored while disabled
        pulse(1);
        acyc_en = 1'b0;
        pulse(1); pulse(3);
        acyc_en = 1'b1;
        #1 chk("R12 gated", in_sel, 2'b01);

        // R10 code 11
        acyc_en = 1'b0; force_en = 1'b1; intm = 2'b11; fm = 2'b11;
        #1 chk("R10 fm 11", in_sel, 2'b00);
        chk("R10 intm 11", ofs_sel, 2'b00);
        // R11 mode table with lbl on
        lbl_en = 1'b1; fm = 2'b10; intm = 2'b01;
        #1 check_all("R11 R4");

        // random mix
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            lbl_en   = $urandom_range(0, 1);
            acyc_en  = $urandom_range(0, 1);
            force_en = $urandom_range(0, 1);
            intm     = 2'($urandom_range(0, 3));
            fm       = 2'($urandom_range(0, 3));
            #1 check_all("rand");
            case ($urandom_range(0, 3))
                0, 1: pulse($urandom_range(1, 6));
                2: clear_strobe();
                default: @(negedge clk);
            endcase
            #1 check_all("rand post");
        end

        done = 1'b1;
        report();
    end

endmodule